// File: doc/BRIEF.md
# Absolute-Value Threshold Detector

The block takes a signed sample and an unsigned threshold and raises a single flag when the sample's magnitude is strictly larger than the threshold. It is aimed at spike detection in front ends, where a sample's distance from zero matters more than its sign.

The magnitude is formed by a sign-steered multiplexer.
- A non-negative sample passes its low bits straight through.
- A negative sample passes its inverted low bits plus one.

That increment is a chain of half-adders, because the added constant has no other non-zero bits. A ripple comparator then works from the least significant bit upward, and each higher bit overrides the decision carried up from below. The carry out of the half-adder chain appears only for the most negative sample, and it forces the flag high.

A parameter selects one of two modes. In the registered mode the block samples on a valid strobe and presents the flag with its own valid one clock later. In the other mode it is purely combinational.

Top module: `absdet_top`

## Requirements
- R1: `sample_in` is a two's-complement number of SAMPLE_W bits (default 4), and its top bit (bit 3) is the sign. `over_out` means |sample| > threshold.
- R2: With the sign bit at 0, the magnitude equals the low three bits. Example: 0011 gives a flag of 1 against threshold 2 and 0 against threshold 3.
- R3: With the sign bit at 1, the magnitude is the inverted low bits plus one. Examples: 1101 (-3) acts as 3 and 1001 (-7) acts as 7.
- R4: Sample 1000 (-8) has magnitude 8 and sets the flag for every threshold from 0 to 7.
- R5: When the magnitude equals the threshold, the flag is 0, since the comparison is strict.
- R6: `thresh_in` is a 3-bit unsigned value from 0 to 7. With threshold 7, only sample 1000 sets the flag. With threshold 0, every sample except 0000 sets it.
- R7: In registered mode, inputs are captured on a rising edge where `valid_in` is 1. `over_out` and `valid_out`=1 appear after that same edge, which is one cycle of latency.
- R8: On an edge where `valid_in` is 0, `valid_out` goes to 0 and `over_out` keeps its previous value, whatever the sample and threshold inputs are.
- R9: A synchronous active-high `rst` clears `over_out` and `valid_out` on the next rising edge.
- R10: A higher differing bit decides the comparison over all lower bits. Magnitude 100 against threshold 011 gives 1, and magnitude 011 against threshold 100 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Sample and threshold are valid this cycle |
| sample_in | input | SAMPLE_W | Two's-complement sample |
| thresh_in | input | SAMPLE_W-1 | Unsigned threshold |
| valid_out | output | 1 | Flag is valid |
| over_out | output | 1 | Magnitude strictly above threshold |

## Verification
The bench sweeps every sample against every threshold and targets a few specific corners.
- **Most negative sample:** a design that dropped the half-adder carry would treat it as magnitude 0 and never flag it.
- **Equal magnitude and threshold:** a comparator written as greater-or-equal would wrongly flag these pairs.
- **Higher bit decides:** pairs where a lower bit favours the opposite answer expose a ripple whose priority runs the wrong way.
- **Idle cycles and reset:** these catch a flag that follows the inputs without `valid_in`, and a reset that fails to clear the outputs.

// File: rtl/absdet_pkg.sv
package absdet_pkg;
  localparam int unsigned ABSDET_SAMPLE_W_DEF = 4;

  typedef enum logic {
    STAGE_COMB = 1'b0,
    STAGE_REG  = 1'b1
  } absdet_stage_e;
endpackage

// File: rtl/absdet_magnitude.sv
module absdet_magnitude #(
  parameter int unsigned SAMPLE_W = 4
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-2:0] mag,
  output logic                mag_ovf
);
  localparam int unsigned MAG_W = SAMPLE_W - 1;

  logic             sign;
  logic [MAG_W-1:0] low;
  logic [MAG_W-1:0] inv;
  logic [MAG_W-1:0] neg_sum;
  logic [MAG_W:0]   carry;

  assign sign     = sample[SAMPLE_W-1];
  assign low      = sample[MAG_W-1:0];
  assign inv      = ~low;
  assign carry[0] = 1'b1;

  // increment of the inverted field: one half-adder per bit
  for (genvar i = 0; i < MAG_W; i++) begin : g_half_add
    assign neg_sum[i]  = inv[i] ^ carry[i];
    assign carry[i+1]  = inv[i] & carry[i];
  end

  assign mag     = sign ? neg_sum : low;
  assign mag_ovf = sign & carry[MAG_W];

  logic [MAG_W-1:0] wrap_chk;
  always_comb begin
    wrap_chk = mag + low;
    if (sign) begin
      AST_NEG_WRAPS: assert (wrap_chk == '0); // R3
    end
    AST_OVF_ONLY_MIN: assert (!mag_ovf || (sign && low == '0)); // R4
  end
endmodule

// File: rtl/absdet_ripple_cmp.sv
module absdet_ripple_cmp #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] mag,
  input  logic [W-1:0] thr,
  output logic         gt
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;

  // bit 0 is resolved first; each stage above overrides it when bits differ
  for (genvar i = 0; i < W; i++) begin : g_stage
    assign chain[i+1] = (mag[i] & ~thr[i]) | (~(mag[i] ^ thr[i]) & chain[i]);
  end

  assign gt = chain[W];

  always_comb begin
    AST_CMP_MATCH: assert (gt == (mag > thr)); // R10
  end
endmodule

// File: rtl/absdet_top.sv
module absdet_top
  import absdet_pkg::*;
#(
  parameter int unsigned   SAMPLE_W = ABSDET_SAMPLE_W_DEF,
  parameter absdet_stage_e STAGE    = STAGE_REG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_in,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [SAMPLE_W-2:0] thresh_in,
  output logic                valid_out,
  output logic                over_out
);
  localparam int unsigned THR_W = SAMPLE_W - 1;

  logic [THR_W-1:0] mag;
  logic             mag_ovf;
  logic             cmp_gt;
  logic             over_c;

  absdet_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .sample (sample_in),
    .mag    (mag),
    .mag_ovf(mag_ovf)
  );

  absdet_ripple_cmp #(.W(THR_W)) u_cmp (
    .mag(mag),
    .thr(thresh_in),
    .gt (cmp_gt)
  );

  assign over_c = mag_ovf | cmp_gt;

  if (STAGE == STAGE_REG) begin : g_reg
    logic over_q;
    logic valid_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        over_q  <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_in;
        if (valid_in) over_q <= over_c;
      end
    end

    assign over_out  = over_q;
    assign valid_out = valid_q;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out); // R7
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> $stable(over_out)); // R8
    AST_MIN_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (valid_in && sample_in == {1'b1, {THR_W{1'b0}}}) |=> over_out); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!valid_out && !over_out)); // R9
  end else begin : g_comb
    assign over_out  = over_c;
    assign valid_out = valid_in;
  end
endmodule

// File: tb/absdet_top_bench.sv
module absdet_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid_in = 1'b0;
  logic [3:0] sample_in = '0;
  logic [2:0] thresh_in = '0;
  logic       valid_out;
  logic       over_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  absdet_top u_absdet_top (
    .clk      (clk),
    .rst      (rst),
    .valid_in (valid_in),
    .sample_in(sample_in),
    .thresh_in(thresh_in),
    .valid_out(valid_out),
    .over_out (over_out)
  );

  // {sample[3:0], threshold[2:0], expected}
  localparam logic [7:0] VEC [14] = '{
    {4'b0011, 3'd2, 1'b1},  // R2
    {4'b0011, 3'd3, 1'b0},  // R2 R5
    {4'b1101, 3'd2, 1'b1},  // R3
    {4'b1101, 3'd3, 1'b0},  // R3 R5
    {4'b1001, 3'd6, 1'b1},  // R3
    {4'b1001, 3'd7, 1'b0},  // R3 R6
    {4'b1000, 3'd7, 1'b1},  // R4
    {4'b1000, 3'd0, 1'b1},  // R4
    {4'b0111, 3'd7, 1'b0},  // R6
    {4'b0000, 3'd0, 1'b0},  // R6
    {4'b1111, 3'd0, 1'b1},  // R6 R1
    {4'b0100, 3'd3, 1'b1},  // R10
    {4'b0011, 3'd4, 1'b0},  // R10
    {4'b1100, 3'd3, 1'b1}   // R10 R3
  };

  function automatic bit ref_flag(input logic [3:0] s, input logic [2:0] t);
    int v;
    v = s[3] ? int'(s) - 16 : int'(s);
    if (v < 0) v = -v;
    return v > int'(t);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic [2:0] t);
    @(negedge clk);
    valid_in  = 1'b1;
    sample_in = s;
    thresh_in = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", valid_out, 1'b0);
    check("R9 reset flag", over_out, 1'b0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      apply(VEC[i][7:4], VEC[i][3:1]);
      check("R1 R2 R3 R4 R5 R6 R10 vector", over_out, VEC[i][0]);
      check("R7 valid", valid_out, 1'b1);
    end

    for (int s = 0; s < 16; s++) begin
      for (int t = 0; t < 8; t++) begin
        apply(4'(s), 3'(t));
        check("R1 sweep", over_out, ref_flag(4'(s), 3'(t)));
      end
    end

    // R8: idle cycle ignores a sample that would flip the flag
    apply(4'b0001, 3'd5);
    check("R8 setup", over_out, 1'b0);
    @(negedge clk);
    valid_in  = 1'b0;
    sample_in = 4'b1000;
    thresh_in = 3'd0;
    @(negedge clk);
    check("R8 hold flag", over_out, 1'b0);
    check("R8 valid low", valid_out, 1'b0);

    // R9: reset clears a set flag
    apply(4'b1000, 3'd1);
    check("R4 before reset", over_out, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 clear flag", over_out, 1'b0);
    check("R9 clear valid", valid_out, 1'b0);
    rst = 1'b0;
    valid_in = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule